// File: doc/BRIEF.md
# Boot-Vector Program Array Slave

This block is the system-bus front end of an on-chip read-only program array. While reset is held it samples three configuration shadow inputs and one strap level, and these choose how it behaves until the next reset. It can stay silent, so that another device answers its addresses. It can serve a one-shot block of four boot vectors from holding registers. It can act as a plain read-only array, or it can move into a locked coprocessor mode that feeds microcode words through a private port.

Bus reads of a byte or an aligned word are answered with a single acknowledge one cycle after the request. A long read is answered with two acknowledges on consecutive cycles. The access is checked against a two-bit address-space field and against an array window set by a base register. Writes to the array are acknowledged and change nothing. A small control-register port holds the stop bit, the space field, the window base and the four boot words.

Top module: `bvf_slave`

## Requirements
- R1: While `rst_n` is low the stop bit is loaded with `shd_stop | ~strap_d12`. While the stop bit is 1, no bus request gets `bus_ack` and `bus_rdata_oe` stays 0. Writing 0 to control register 0 bit 15 clears the stop bit.
- R2: With every shadow input at 1 (erased) and the strap high, the block leaves reset with the stop bit set.
- R3: If `shd_boot`=0 and the sampled stop bit is 0, a program-space read (`bus_fc[1:0]`=2'b10) at an address below 8 returns boot word `bus_addr[2:1]`. A read with any other function code at those addresses gets no acknowledge.
- R4: Boot mode ends at the clock edge that delivers the full word at address 6, through a word read or the second half of a long read at 4, and stays off until reset. Later accesses to those addresses are answered only if the array window covers them.
- R5: If boot mode and automatic coprocessor mode (`shd_tme`=0) are both chosen at reset, the microcode port gives no acknowledge until boot mode has ended. After that it serves requests.
- R6: A byte or word read gets `bus_ack` one cycle after `bus_req`. A long read (`bus_size`=2) gets two acknowledges on consecutive cycles, first the word at the address and then the word at address+2. A byte read returns the addressed byte in both halves, with an even address taking bits 15:8. `bus_size` values: 0 byte, 1 word, 2 long.
- R7: Array accesses are answered only if the space field (control register 0 bits 1:0) allows them. Bit 1 set requires `bus_fc[2]`=1 (supervisor). Bit 0 set requires `bus_fc[1:0]`=2'b10 (program).
- R8: An array write gets one `bus_ack` with `bus_rdata_oe`=0 and leaves the array content unchanged.
- R9: The array window is the set of addresses whose bits 23:8 equal the base register. A word at an odd address, a long at an address not a multiple of 4, an unknown size, or an address outside both windows gets no acknowledge. `bus_rdata` is 0 whenever `bus_rdata_oe` is 0.
- R10: Coprocessor mode is entered on a pulse of `emu_set` or from `shd_tme`=0. In this mode control-register writes are ignored and reads still return the stored values.
- R11: The microcode port answers `uc_req` with `uc_ack` and array word `uc_addr` one cycle later, and only in coprocessor mode.
- R12: Array word i holds `((i * 0x9E37) mod 65536) XOR 0x5AC3`.
- R13: Control registers: 0 holds {stop at bit 15, space at bits 1:0}, 1 holds the base, and 2 to 5 hold boot words 0 to 3. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode inputs sampled while low |
| shd_stop | input | 1 | Stop shadow bit (erased = 1) |
| shd_boot | input | 1 | Boot shadow bit, 0 selects boot vectors |
| shd_tme | input | 1 | Coprocessor-mode shadow bit, 0 selects auto entry |
| strap_d12 | input | 1 | Data bit 12 level during reset, low forces stop |
| emu_set | input | 1 | Coprocessor-side emulation request pulse |
| bus_req | input | 1 | One-cycle access request |
| bus_addr | input | 24 | Byte address |
| bus_fc | input | 3 | Function code |
| bus_size | input | 2 | 0 byte, 1 word, 2 long |
| bus_wr | input | 1 | 1 = write |
| bus_wdata | input | 16 | Write data (discarded) |
| bus_ack | output | 1 | Access acknowledge |
| bus_rdata | output | 16 | Read data |
| bus_rdata_oe | output | 1 | Read data is being driven |
| cr_sel | input | 1 | Control-register access |
| cr_wr | input | 1 | Control-register write |
| cr_addr | input | 3 | Control-register index |
| cr_wdata | input | 16 | Control-register write data |
| cr_rdata | output | 16 | Control-register read data |
| uc_req | input | 1 | Microcode read request |
| uc_addr | input | 7 | Microcode word index |
| uc_ack | output | 1 | Microcode acknowledge |
| uc_data | output | 16 | Microcode word |

## Verification
The assertions assume that a bus master issues `bus_req` for a single cycle and never during the second half of a long read. They also assume the stop bit and the window base do not change while a long read is in progress. The bench drives each access from a task that waits out both possible acknowledge cycles before the next request, and it writes control registers only between accesses. Because of this, every checked response belongs to exactly one request.

// File: rtl/bvf_pkg.sv
package bvf_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2
    } size_e;

    localparam logic [1:0] FC_PROG = 2'b10;

    // Behavioural array content: a cheap multiplicative hash of the index.
    function automatic logic [15:0] rom_word(input logic [31:0] idx);
        logic [31:0] prod;
        prod = idx * 32'h0000_9E37;
        return prod[15:0] ^ 16'h5AC3;
    endfunction

endpackage

// File: rtl/bvf_mode.sv
module bvf_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_rst_i,
    input  logic sh_boot_i,
    input  logic sh_tme_i,
    input  logic emu_set_i,
    input  logic boot_done_i,
    output logic boot_o,
    output logic copro_o
);

    typedef struct packed {
        logic boot;
        logic pend;
        logic copro;
    } mode_s;

    mode_s m_d, m_q;

    always_comb begin
        m_d = m_q;
        if (boot_done_i) m_d.boot = 1'b0;
        if (emu_set_i)   m_d.pend = 1'b1;
        // bootstrap reads keep priority over coprocessor entry
        if (m_q.pend && !m_q.boot) m_d.copro = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q.boot  <= !sh_boot_i && !stop_rst_i;
            m_q.pend  <= !sh_tme_i;
            m_q.copro <= 1'b0;
        end else begin
            m_q <= m_d;
        end
    end

    assign boot_o  = m_q.boot;
    assign copro_o = m_q.copro;

    // R4
    boot_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(m_q.boot) |-> $past(boot_done_i));

    // R4
    boot_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !m_q.boot |=> !m_q.boot);

endmodule

// File: rtl/bvf_regs.sv
module bvf_regs #(
    parameter int unsigned        BASE_W   = 16,
    parameter logic [BASE_W-1:0]  BASE_RST = '0,
    parameter logic [3:0][15:0]   BOOT_RST = '0
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   stop_rst_i,
    input  logic                   copro_i,
    input  logic                   cr_sel_i,
    input  logic                   cr_wr_i,
    input  logic [2:0]             cr_addr_i,
    input  logic [15:0]            cr_wdata_i,
    output logic [15:0]            cr_rdata_o,
    output logic                   stop_o,
    output logic [1:0]             space_o,
    output logic [BASE_W-1:0]      base_o,
    output logic [3:0][15:0]       boot_word_o
);

    typedef struct packed {
        logic                 stop;
        logic [1:0]           space;
        logic [BASE_W-1:0]    base;
        logic [3:0][15:0]     bw;
    } regs_s;

    regs_s s_d, s_q;
    logic [2:0] widx;

    assign widx = cr_addr_i - 3'd2;

    always_comb begin
        s_d = s_q;
        if (cr_sel_i && cr_wr_i && !copro_i) begin
            case (cr_addr_i)
                3'd0: begin
                    s_d.stop  = cr_wdata_i[15];
                    s_d.space = cr_wdata_i[1:0];
                end
                3'd1:                   s_d.base = cr_wdata_i[BASE_W-1:0];
                3'd2, 3'd3, 3'd4, 3'd5: s_d.bw[widx[1:0]] = cr_wdata_i;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (cr_addr_i)
            3'd0:                   cr_rdata_o = {s_q.stop, 13'd0, s_q.space};
            3'd1:                   cr_rdata_o = 16'(s_q.base);
            3'd2, 3'd3, 3'd4, 3'd5: cr_rdata_o = s_q.bw[widx[1:0]];
            default:                cr_rdata_o = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.stop  <= stop_rst_i;
            s_q.space <= '0;
            s_q.base  <= BASE_RST;
            s_q.bw    <= BOOT_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign stop_o      = s_q.stop;
    assign space_o     = s_q.space;
    assign base_o      = s_q.base;
    assign boot_word_o = s_q.bw;

    // R10
    cfg_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        copro_i |=> ($stable(base_o) && $stable(space_o) && $stable(stop_o)
                     && $stable(boot_word_o)));

endmodule

// File: rtl/bvf_rom.sv
module bvf_rom #(
    parameter int unsigned AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          copro_i,
    input  logic [AW-1:0] sys_idx_i,
    output logic [15:0]   sys_word_o,
    input  logic          uc_req_i,
    input  logic [AW-1:0] uc_addr_i,
    output logic          uc_ack_o,
    output logic [15:0]   uc_data_o
);
    import bvf_pkg::*;

    typedef struct packed {
        logic        ack;
        logic [15:0] data;
    } uc_s;

    uc_s u_d, u_q;

    assign sys_word_o = rom_word(32'(sys_idx_i));

    always_comb begin
        u_d      = '0;
        if (uc_req_i && copro_i) begin
            u_d.ack  = 1'b1;
            u_d.data = rom_word(32'(uc_addr_i));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) u_q <= '0;
        else        u_q <= u_d;
    end

    assign uc_ack_o  = u_q.ack;
    assign uc_data_o = u_q.data;

    // R11
    uc_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !copro_i |=> !uc_ack_o);

endmodule

// File: rtl/bvf_bus.sv
module bvf_bus #(
    parameter int unsigned ADDR_W = 24,
    parameter int unsigned AW     = 7,
    parameter int unsigned BASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_i,
    input  logic [ADDR_W-1:0]  req_addr_i,
    input  logic [2:0]         req_fc_i,
    input  logic [1:0]         req_size_i,
    input  logic               req_wr_i,
    input  logic               stop_i,
    input  logic               boot_i,
    input  logic [1:0]         space_i,
    input  logic [BASE_W-1:0]  base_i,
    input  logic [3:0][15:0]   boot_word_i,
    input  logic [15:0]        rom_word_i,
    output logic [AW-1:0]      rom_idx_o,
    output logic               boot_done_o,
    output logic               bus_ack,
    output logic [15:0]        bus_rdata,
    output logic               bus_rdata_oe
);
    import bvf_pkg::*;

    localparam int unsigned WIN_SH = AW + 1;

    typedef struct packed {
        logic          ack;
        logic          rd;
        logic [15:0]   data;
        logic          pend;
        logic          pend_vec;
        logic [AW-1:0] nidx;
        logic [1:0]    nvec;
    } bus_s;

    bus_s s_d, s_q;

    logic       hit_vec, hit_arr, space_ok, align_ok, take, fin;
    logic [1:0] vidx;
    logic [15:0] word;

    assign vidx     = req_addr_i[2:1];
    assign hit_vec  = boot_i && (req_addr_i[ADDR_W-1:3] == '0) && (req_fc_i[1:0] == FC_PROG);
    assign hit_arr  = (req_addr_i[ADDR_W-1:WIN_SH] == base_i);
    assign space_ok = !(space_i[1] && !req_fc_i[2]) &&
                      !(space_i[0] && (req_fc_i[1:0] != FC_PROG));

    always_comb begin
        case (req_size_i)
            SZ_BYTE: align_ok = 1'b1;
            SZ_WORD: align_ok = !req_addr_i[0];
            SZ_LONG: align_ok = (req_addr_i[1:0] == 2'b00);
            default: align_ok = 1'b0;
        endcase
    end

    assign take      = req_i && !s_q.pend && !stop_i && align_ok &&
                       (hit_vec || (hit_arr && space_ok));
    assign rom_idx_o = s_q.pend ? s_q.nidx : req_addr_i[AW:1];
    assign word      = hit_vec ? boot_word_i[vidx] : rom_word_i;

    always_comb begin
        s_d      = s_q;
        s_d.ack  = 1'b0;
        s_d.rd   = 1'b0;
        s_d.data = '0;
        s_d.pend = 1'b0;
        fin      = 1'b0;
        if (s_q.pend) begin
            s_d.ack  = 1'b1;
            s_d.rd   = 1'b1;
            s_d.data = s_q.pend_vec ? boot_word_i[s_q.nvec] : rom_word_i;
            fin      = s_q.pend_vec && (s_q.nvec == 2'd3);
        end else if (take) begin
            s_d.ack = 1'b1;
            if (!req_wr_i) begin
                s_d.rd = 1'b1;
                if (req_size_i == SZ_BYTE)
                    s_d.data = req_addr_i[0] ? {word[7:0], word[7:0]}
                                             : {word[15:8], word[15:8]};
                else
                    s_d.data = word;
                if (req_size_i == SZ_LONG) begin
                    s_d.pend     = 1'b1;
                    s_d.pend_vec = hit_vec;
                    s_d.nidx     = req_addr_i[AW:1] + 1'b1;
                    s_d.nvec     = vidx + 2'd1;
                end
                fin = hit_vec && (req_size_i == SZ_WORD) && (vidx == 2'd3);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign boot_done_o  = fin;
    assign bus_ack      = s_q.ack;
    assign bus_rdata_oe = s_q.rd;
    assign bus_rdata    = s_q.rd ? s_q.data : 16'd0;

    // R1
    stop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && req_i && !s_q.pend) |=> !bus_ack);

    // R6
    long_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ack && bus_rdata_oe && $past(req_i) && ($past(req_size_i) == 2'd2)
         && !$past(s_q.pend)) |=> (bus_ack && bus_rdata_oe));

    // R9
    oe_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata_oe |-> bus_ack);

    // R9
    idle_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rdata_oe |-> (bus_rdata == 16'd0));

endmodule

// File: rtl/bvf_slave.sv
module bvf_slave #(
    parameter int unsigned      ADDR_W   = 24,
    parameter int unsigned      AW       = 7,
    parameter logic [15:0]      BASE_RST = 16'h0100,
    parameter logic [3:0][15:0] BOOT_RST = {16'hB003, 16'hB002, 16'hB001, 16'hB000}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shd_stop,
    input  logic              shd_boot,
    input  logic              shd_tme,
    input  logic              strap_d12,
    input  logic              emu_set,
    input  logic              bus_req,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [2:0]        bus_fc,
    input  logic [1:0]        bus_size,
    input  logic              bus_wr,
    input  logic [15:0]       bus_wdata,
    output logic              bus_ack,
    output logic [15:0]       bus_rdata,
    output logic              bus_rdata_oe,
    input  logic              cr_sel,
    input  logic              cr_wr,
    input  logic [2:0]        cr_addr,
    input  logic [15:0]       cr_wdata,
    output logic [15:0]       cr_rdata,
    input  logic              uc_req,
    input  logic [AW-1:0]     uc_addr,
    output logic              uc_ack,
    output logic [15:0]       uc_data
);

    localparam int unsigned WIN_SH = AW + 1;
    localparam int unsigned BASE_W = ADDR_W - WIN_SH;

    logic                  stop_rst, stop, boot, copro, boot_done;
    logic [1:0]            space;
    logic [BASE_W-1:0]     base;
    logic [3:0][15:0]      boot_word;
    logic [AW-1:0]         rom_idx;
    logic [15:0]           rom_word;
    logic                  unused_wdata;

    assign stop_rst     = shd_stop | ~strap_d12;
    assign unused_wdata = ^bus_wdata;

    bvf_mode u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_rst_i  (stop_rst),
        .sh_boot_i   (shd_boot),
        .sh_tme_i    (shd_tme),
        .emu_set_i   (emu_set),
        .boot_done_i (boot_done),
        .boot_o      (boot),
        .copro_o     (copro)
    );

    bvf_regs #(
        .BASE_W   (BASE_W),
        .BASE_RST (BASE_RST[BASE_W-1:0]),
        .BOOT_RST (BOOT_RST)
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .stop_rst_i  (stop_rst),
        .copro_i     (copro),
        .cr_sel_i    (cr_sel),
        .cr_wr_i     (cr_wr),
        .cr_addr_i   (cr_addr),
        .cr_wdata_i  (cr_wdata),
        .cr_rdata_o  (cr_rdata),
        .stop_o      (stop),
        .space_o     (space),
        .base_o      (base),
        .boot_word_o (boot_word)
    );

    bvf_rom #(.AW(AW)) u_rom (
        .clk        (clk),
        .rst_n      (rst_n),
        .copro_i    (copro),
        .sys_idx_i  (rom_idx),
        .sys_word_o (rom_word),
        .uc_req_i   (uc_req),
        .uc_addr_i  (uc_addr),
        .uc_ack_o   (uc_ack),
        .uc_data_o  (uc_data)
    );

    bvf_bus #(
        .ADDR_W (ADDR_W),
        .AW     (AW),
        .BASE_W (BASE_W)
    ) u_bus (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_i        (bus_req),
        .req_addr_i   (bus_addr),
        .req_fc_i     (bus_fc),
        .req_size_i   (bus_size),
        .req_wr_i     (bus_wr),
        .stop_i       (stop),
        .boot_i       (boot),
        .space_i      (space),
        .base_i       (base),
        .boot_word_i  (boot_word),
        .rom_word_i   (rom_word),
        .rom_idx_o    (rom_idx),
        .boot_done_o  (boot_done),
        .bus_ack      (bus_ack),
        .bus_rdata    (bus_rdata),
        .bus_rdata_oe (bus_rdata_oe)
    );

    // R5
    uc_after_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot |=> !uc_ack);

endmodule

// File: tb/sim_bvf_slave.sv
module sim_bvf_slave;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shd_stop = 1'b1, shd_boot = 1'b1, shd_tme = 1'b1, strap_d12 = 1'b1;
    logic        emu_set = 1'b0;
    logic        bus_req = 1'b0, bus_wr = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [2:0]  bus_fc = 3'b110;
    logic [1:0]  bus_size = 2'd1;
    logic [15:0] bus_wdata = '0;
    logic        bus_ack, bus_rdata_oe;
    logic [15:0] bus_rdata;
    logic        cr_sel = 1'b0, cr_wr = 1'b0;
    logic [2:0]  cr_addr = '0;
    logic [15:0] cr_wdata = '0, cr_rdata;
    logic        uc_req = 1'b0;
    logic [6:0]  uc_addr = '0;
    logic        uc_ack;
    logic [15:0] uc_data;

    int nchk = 0;
    int nerr = 0;
    logic        a1, a2, o1;
    logic [15:0] d1, d2, rv;

    localparam logic [23:0] ARR = 24'h010000;

    always #5 clk = ~clk;

    bvf_slave u0 (.*);

    function automatic logic [15:0] exp_rom(input int i);
        logic [31:0] p;
        p = i * 32'h9E37;
        return p[15:0] ^ 16'h5AC3;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic s, input logic b, input logic t, input logic strap);
        @(negedge clk);
        rst_n = 1'b0; shd_stop = s; shd_boot = b; shd_tme = t; strap_d12 = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        strap_d12 = 1'b1;
        @(negedge clk);
    endtask

    task automatic acc(input logic wr, input logic [23:0] a, input logic [2:0] fc, input logic [1:0] sz);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_fc = fc; bus_size = sz;
        bus_wdata = 16'hFFFF;
        @(negedge clk);
        bus_req = 1'b0;
        a1 = bus_ack; o1 = bus_rdata_oe; d1 = bus_rdata;
        @(negedge clk);
        a2 = bus_ack; d2 = bus_rdata;
    endtask

    task automatic crw(input logic [2:0] a, input logic [15:0] v);
        cr_sel = 1'b1; cr_wr = 1'b1; cr_addr = a; cr_wdata = v;
        @(negedge clk);
        cr_sel = 1'b0; cr_wr = 1'b0;
    endtask

    task automatic crr(input logic [2:0] a);
        cr_sel = 1'b1; cr_wr = 1'b0; cr_addr = a;
        #1 rv = cr_rdata;
        cr_sel = 1'b0;
    endtask

    task automatic ucr(input logic [6:0] a);
        uc_req = 1'b1; uc_addr = a;
        @(negedge clk);
        uc_req = 1'b0;
        a1 = uc_ack; d1 = uc_data;
    endtask

    task automatic report;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        // erased module
        do_reset(1'b1, 1'b1, 1'b1, 1'b1);
        crr(3'd0);
        chk("R2 erased stop bit", rv[15], 1'b1);
        acc(1'b0, ARR, 3'b110, 2'd1);
        chk("R1 stopped array ack", {a1, o1}, 2'b00);
        chk("R9 stopped data idle", d1, 16'h0);
        acc(1'b0, 24'h0, 3'b110, 2'd1);
        chk("R1 stopped vector ack", a1, 1'b0);

        // strap low forces stop
        do_reset(1'b0, 1'b1, 1'b1, 1'b0);
        crr(3'd0);
        chk("R1 strap stop bit", rv[15], 1'b1);
        acc(1'b0, ARR + 24'd4, 3'b110, 2'd1);
        chk("R1 strap stop ack", a1, 1'b0);
        crw(3'd0, 16'h0000);
        crr(3'd0);
        chk("R13 cfg read", rv, 16'h0000);
        acc(1'b0, ARR + 24'd4, 3'b110, 2'd1);
        chk("R1 released ack", a1, 1'b1);
        chk("R12 released data", d1, exp_rom(2));

        // normal mode sweeps
        do_reset(1'b0, 1'b1, 1'b1, 1'b1);
        crr(3'd1);
        chk("R13 base reset", rv, 16'h0100);
        crr(3'd6);
        chk("R13 unused reg", rv, 16'h0);
        for (int i = 0; i < 128; i++) begin
            acc(1'b0, ARR + 24'(2 * i), 3'b110, 2'd1);
            chk("R12 word ack", {a1, o1, a2}, 3'b110);
            chk("R12 word data", d1, exp_rom(i));
        end
        for (int i = 0; i < 256; i++) begin
            logic [15:0] w;
            logic [7:0]  b;
            w = exp_rom(i / 2);
            b = (i % 2 == 1) ? w[7:0] : w[15:8];
            acc(1'b0, ARR + 24'(i), 3'b110, 2'd0);
            chk("R6 byte", {a1, a2, d1}, {1'b1, 1'b0, b, b});
        end
        for (int i = 0; i < 64; i++) begin
            acc(1'b0, ARR + 24'(4 * i), 3'b110, 2'd2);
            chk("R6 long acks", {a1, a2}, 2'b11);
            chk("R6 long words", {d1, d2}, {exp_rom(2 * i), exp_rom(2 * i + 1)});
        end
        acc(1'b0, ARR + 24'd3, 3'b110, 2'd1);
        chk("R9 odd word", {a1, o1}, 2'b00);
        acc(1'b0, ARR + 24'd2, 3'b110, 2'd2);
        chk("R9 misaligned long", a1, 1'b0);
        acc(1'b0, ARR + 24'd8, 3'b110, 2'd3);
        chk("R9 bad size", a1, 1'b0);
        acc(1'b0, ARR + 24'h100, 3'b110, 2'd1);
        chk("R9 above window", a1, 1'b0);
        acc(1'b0, ARR - 24'd2, 3'b110, 2'd1);
        chk("R9 below window", a1, 1'b0);
        acc(1'b0, 24'h0, 3'b110, 2'd1);
        chk("R4 no vectors in normal", a1, 1'b0);
        acc(1'b1, ARR + 24'h10, 3'b110, 2'd1);
        chk("R8 write ack", {a1, o1, a2}, 3'b100);
        acc(1'b0, ARR + 24'h10, 3'b110, 2'd1);
        chk("R8 write no change", d1, exp_rom(8));
        crw(3'd1, 16'h0200);
        acc(1'b0, 24'h020006, 3'b110, 2'd1);
        chk("R9 moved window", {a1, d1}, {1'b1, exp_rom(3)});
        acc(1'b0, ARR + 24'd6, 3'b110, 2'd1);
        chk("R9 old window", a1, 1'b0);
        crw(3'd1, 16'h0100);
        for (int sp = 0; sp < 4; sp++) begin
            crw(3'd0, 16'(sp));
            for (int fc = 0; fc < 8; fc++) begin
                logic ok;
                ok = !((sp & 2) != 0 && (fc & 4) == 0) && !((sp & 1) != 0 && (fc & 3) != 2);
                acc(1'b0, ARR, 3'(fc), 2'd1);
                chk("R7 space check", a1, ok);
            end
        end
        crw(3'd0, 16'h0000);
        ucr(7'd5);
        chk("R11 uc idle outside copro", a1, 1'b0);
        emu_set = 1'b1;
        @(negedge clk);
        emu_set = 1'b0;
        repeat (2) @(negedge clk);
        ucr(7'd5);
        chk("R11 uc word", {a1, d1}, {1'b1, exp_rom(5)});
        ucr(7'd127);
        chk("R11 uc last word", {a1, d1}, {1'b1, exp_rom(127)});
        crw(3'd1, 16'h0300);
        crr(3'd1);
        chk("R10 base write blocked", rv, 16'h0100);
        crw(3'd0, 16'h8000);
        acc(1'b0, ARR, 3'b110, 2'd1);
        chk("R10 stop write blocked", {a1, d1}, {1'b1, exp_rom(0)});

        // bootstrap mode
        do_reset(1'b0, 1'b0, 1'b1, 1'b1);
        for (int v = 0; v < 3; v++) begin
            acc(1'b0, 24'(2 * v), 3'b110, 2'd1);
            chk("R3 vector word", {a1, d1}, {1'b1, 16'hB000 + 16'(v)});
        end
        acc(1'b0, 24'h0, 3'b101, 2'd1);
        chk("R3 data space vector", a1, 1'b0);
        acc(1'b0, 24'h5, 3'b010, 2'd0);
        chk("R3 vector byte", {a1, d1}, {1'b1, 16'h0202});
        acc(1'b0, 24'h0, 3'b110, 2'd2);
        chk("R6 vector long", {a1, a2, d1, d2}, {2'b11, 16'hB000, 16'hB001});
        acc(1'b0, 24'h4, 3'b110, 2'd2);
        chk("R3 last pair", {a1, a2, d1, d2}, {2'b11, 16'hB002, 16'hB003});
        acc(1'b0, 24'h0, 3'b110, 2'd1);
        chk("R4 boot finished", a1, 1'b0);
        crw(3'd1, 16'h0000);
        acc(1'b0, 24'h2, 3'b110, 2'd1);
        chk("R4 array after boot", {a1, d1}, {1'b1, exp_rom(1)});
        ucr(7'd1);
        chk("R11 no uc without tme", a1, 1'b0);

        // bootstrap then automatic coprocessor mode
        do_reset(1'b0, 1'b0, 1'b0, 1'b1);
        repeat (3) @(negedge clk);
        ucr(7'd9);
        chk("R5 uc held during boot", a1, 1'b0);
        crw(3'd3, 16'h1234);
        crr(3'd3);
        chk("R13 boot word write", rv, 16'h1234);
        acc(1'b0, 24'h2, 3'b110, 2'd1);
        chk("R3 rewritten vector", {a1, d1}, {1'b1, 16'h1234});
        acc(1'b0, 24'h6, 3'b110, 2'd1);
        chk("R4 final vector", {a1, d1}, {1'b1, 16'hB003});
        ucr(7'd9);
        chk("R5 uc after boot", {a1, d1}, {1'b1, exp_rom(9)});
        crw(3'd2, 16'hFFFF);
        crr(3'd2);
        chk("R10 boot word locked", rv, 16'hB000);

        report();
    end

endmodule